// File: doc/BRIEF.md
# Page Translation Cache with Pinned Entries

This block is a small, fully associative cache of virtual-to-physical page translations. Each slot holds a 22-bit virtual page tag, taken from address bits 31:10, and a 22-bit physical page number. It also holds a valid flag and a pin flag. A lookup port translates an address in the same cycle. A single command port carries four operations: fill, bulk flush, flush of a single address, and no-op.

A pinned slot survives the bulk flush, so critical mappings stay resident across context switches. Flushing a single address removes the matching slot whether or not it is pinned. When the table is full, a fill takes the slot of a matching tag if there is one. Otherwise it evicts an unpinned slot in rotating order. When every slot is pinned and none matches, the fill is refused and flagged.

Top module: `pvtlb_top`

## Requirements
- R1: After synchronous reset every slot is empty and every lookup misses.
- R2: A lookup is combinational. `lk_hit` is 1 in the same cycle when exactly one valid slot's tag equals `lk_addr[31:10]`, and `lk_ppn` then returns that slot's page. On a miss `lk_ppn` is 0.
- R3: A bulk flush (`cmd_op` = 2) clears every valid slot whose pin flag is 0 and leaves pinned slots valid.
- R4: A single flush (`cmd_op` = 3) clears the slot whose tag equals `cmd_addr[31:10]`, even when that slot is pinned.
- R5: Address bits 9:0 are ignored by lookups and by single flushes.
- R6: A fill (`cmd_op` = 1) of a tag that is already present rewrites that slot's page and pin flag in place, and no other mapping is displaced.
- R7: A fill of a new tag goes into the lowest-numbered empty slot when one exists, so no valid mapping is lost.
- R8: A fill of a new tag into a full table replaces an unpinned slot. A pointer that starts at slot 0 names the candidate. The victim is the first unpinned slot at or after the pointer, wrapping around. The pointer then moves to the victim plus one, modulo the depth.
- R9: A fill of a new tag into a full table whose slots are all pinned changes nothing. It raises `fill_err` for exactly the one cycle after the command.
- R10: Every command is applied at the clock edge that samples it, and a lookup in the next cycle sees the result.
- R11: Each 1 KB subpage has its own tag and is matched and flushed separately from its neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 no-op, 1 fill, 2 bulk flush, 3 single flush |
| cmd_addr | input | 32 | Virtual address; bits 31:10 form the tag |
| cmd_ppn | input | 22 | Physical page written by a fill |
| cmd_preserve | input | 1 | Pin flag written by a fill |
| lk_addr | input | 32 | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | 22 | Physical page on a hit, else 0 |
| fill_err | output | 1 | One-cycle pulse for a refused fill |

## Verification
Lookup results depend on the inputs of the current cycle. A command changes them from the cycle after the edge that samples it. `fill_err` is registered and is high for exactly that following cycle. The bench drives commands just after a rising edge. Its behavioural model applies each command at the edge where the design samples it. The bench compares lookup outputs and `fill_err` against the model on every falling edge. Directed checks sample one cycle after each command, and the pulse check samples again one cycle later to confirm that `fill_err` has dropped.

// File: rtl/pvtlb_pkg.sv
package pvtlb_pkg;
  typedef enum logic [1:0] {
    OP_NOP     = 2'd0,
    OP_FILL    = 2'd1,
    OP_FLUSH   = 2'd2,
    OP_DROP    = 2'd3
  } tlb_op_e;
endpackage

// File: rtl/pvtlb_match.sv
// Parallel tag comparator: one equality per slot, gated by valid.
module pvtlb_match #(
  parameter int N  = 8,
  parameter int TW = 22
) (
  input  logic [N-1:0]    ent_valid,
  input  logic [N*TW-1:0] ent_tags,
  input  logic [TW-1:0]   key,
  output logic [N-1:0]    hit_vec
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_tags[g*TW +: TW] == key);
  end
endmodule

// File: rtl/pvtlb_store.sv
// Slot storage: flags with reset, payload without reset.
module pvtlb_store #(
  parameter int N  = 8,
  parameter int TW = 22,
  parameter int PW = 22,
  localparam int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [TW-1:0]   wr_tag,
  input  logic [PW-1:0]   wr_ppn,
  input  logic            wr_pres,
  input  logic [N-1:0]    clr_mask,
  output logic [N-1:0]    ent_valid,
  output logic [N-1:0]    ent_pres,
  output logic [N*TW-1:0] ent_tags,
  output logic [N*PW-1:0] ent_ppns
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IW'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[g] <= 1'b0;
        ent_pres[g]  <= 1'b0;
      end else if (sel) begin
        ent_valid[g] <= 1'b1;
        ent_pres[g]  <= wr_pres;
      end else if (clr_mask[g]) begin
        ent_valid[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        ent_tags[g*TW +: TW] <= wr_tag;
        ent_ppns[g*PW +: PW] <= wr_ppn;
      end
    end
  end
endmodule

// File: rtl/pvtlb_victim.sv
// Slot choice for a fill: matching slot, else lowest empty, else
// rotating search for an unpinned slot starting at rr_ptr.
module pvtlb_victim #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  ent_valid,
  input  logic [N-1:0]  ent_pres,
  input  logic [N-1:0]  hit_vec,
  input  logic [IW-1:0] rr_ptr,
  output logic [IW-1:0] sel_idx,
  output logic          sel_ok,
  output logic          sel_repl
);
  logic [IW-1:0] hit_idx, free_idx, rot_idx;
  logic          hit_any, free_any, rot_any;

  always_comb begin
    hit_idx  = '0;
    hit_any  = 1'b0;
    free_idx = '0;
    free_any = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit_vec[k]) begin
        hit_idx = IW'(k);
        hit_any = 1'b1;
      end
      if (!ent_valid[k]) begin
        free_idx = IW'(k);
        free_any = 1'b1;
      end
    end
  end

  always_comb begin
    rot_idx = '0;
    rot_any = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(rr_ptr) + k;
      if (j >= N) j = j - N;
      if (!rot_any && !ent_pres[j]) begin
        rot_idx = IW'(j);
        rot_any = 1'b1;
      end
    end
  end

  always_comb begin
    sel_idx  = '0;
    sel_ok   = 1'b0;
    sel_repl = 1'b0;
    if (hit_any) begin
      sel_idx = hit_idx;
      sel_ok  = 1'b1;
    end else if (free_any) begin
      sel_idx = free_idx;
      sel_ok  = 1'b1;
    end else if (rot_any) begin
      sel_idx  = rot_idx;
      sel_ok   = 1'b1;
      sel_repl = 1'b1;
    end
  end
endmodule

// File: rtl/pvtlb_top.sv
module pvtlb_top #(
  parameter int N   = 8,
  parameter int AW  = 32,
  parameter int OFF = 10,
  parameter int PW  = 22
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [PW-1:0] cmd_ppn,
  input  logic          cmd_preserve,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [PW-1:0] lk_ppn,
  output logic          fill_err
);
  import pvtlb_pkg::*;
  localparam int TW = AW - OFF;
  localparam int IW = $clog2(N);

  tlb_op_e         op;
  logic [TW-1:0]   cmd_tag, lk_tag;
  logic            do_fill, do_flush, do_drop;
  logic [N-1:0]    ent_valid, ent_pres, cmd_vec, lk_vec, clr_mask;
  logic [N*TW-1:0] ent_tags;
  logic [N*PW-1:0] ent_ppns;
  logic [IW-1:0]   rr_ptr, sel_idx;
  logic            sel_ok, sel_repl, wr_en;
  logic [PW-1:0]   ppn_or;

  assign op       = tlb_op_e'(cmd_op);
  assign cmd_tag  = cmd_addr[AW-1:OFF];
  assign lk_tag   = lk_addr[AW-1:OFF];
  assign do_fill  = cmd_valid && (op == OP_FILL);
  assign do_flush = cmd_valid && (op == OP_FLUSH);
  assign do_drop  = cmd_valid && (op == OP_DROP);
  assign wr_en    = do_fill && sel_ok;

  always_comb begin
    clr_mask = '0;
    if (do_flush)     clr_mask = ~ent_pres;
    else if (do_drop) clr_mask = cmd_vec;
  end

  pvtlb_match #(.N(N), .TW(TW)) u_cmd_match (
    .ent_valid(ent_valid), .ent_tags(ent_tags), .key(cmd_tag), .hit_vec(cmd_vec)
  );

  pvtlb_match #(.N(N), .TW(TW)) u_lk_match (
    .ent_valid(ent_valid), .ent_tags(ent_tags), .key(lk_tag), .hit_vec(lk_vec)
  );

  pvtlb_victim #(.N(N)) u_victim (
    .ent_valid(ent_valid), .ent_pres(ent_pres), .hit_vec(cmd_vec),
    .rr_ptr(rr_ptr), .sel_idx(sel_idx), .sel_ok(sel_ok), .sel_repl(sel_repl)
  );

  pvtlb_store #(.N(N), .TW(TW), .PW(PW)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(sel_idx), .wr_tag(cmd_tag),
    .wr_ppn(cmd_ppn), .wr_pres(cmd_preserve), .clr_mask(clr_mask),
    .ent_valid(ent_valid), .ent_pres(ent_pres), .ent_tags(ent_tags),
    .ent_ppns(ent_ppns)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_ptr   <= '0;
      fill_err <= 1'b0;
    end else begin
      fill_err <= do_fill && !sel_ok;
      if (wr_en && sel_repl)
        rr_ptr <= (int'(sel_idx) == N - 1) ? '0 : sel_idx + 1'b1;
    end
  end

  always_comb begin
    ppn_or = '0;
    for (int k = 0; k < N; k++)
      if (lk_vec[k]) ppn_or = ppn_or | ent_ppns[k*PW +: PW];
  end

  assign lk_hit = ($countones(lk_vec) == 1);
  assign lk_ppn = lk_hit ? ppn_or : '0;
endmodule

// File: rtl/pvtlb_chk.sv
module pvtlb_chk #(
  parameter int N   = 8,
  parameter int AW  = 32,
  parameter int OFF = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [1:0]    cmd_op,
  input logic [AW-1:0] cmd_addr,
  input logic [AW-1:0] lk_addr,
  input logic          lk_hit,
  input logic          fill_err,
  input logic [N-1:0]  ent_valid,
  input logic [N-1:0]  ent_pres,
  input logic [N-1:0]  lk_vec
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ent_valid == '0) && !lk_hit); // R1

  AST_FLUSH_KEEPS_PINNED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2) |=>
      (ent_valid == ($past(ent_valid) & $past(ent_pres)))); // R3

  AST_DROP_MISSES: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3) |=>
      !(lk_hit && lk_addr[AW-1:OFF] == $past(cmd_addr[AW-1:OFF]))); // R4

  AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (rst)
    $countones(lk_vec) <= 1); // R6

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1) |=>
      (fill_err || lk_hit || lk_addr[AW-1:OFF] != $past(cmd_addr[AW-1:OFF]))); // R10

  AST_ERR_AFTER_FILL: assert property (@(posedge clk) disable iff (rst)
    fill_err |-> $past(cmd_valid && cmd_op == 2'd1)); // R9
endmodule

bind pvtlb_top pvtlb_chk #(.N(N), .AW(AW), .OFF(OFF)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .lk_addr(lk_addr), .lk_hit(lk_hit),
  .fill_err(fill_err), .ent_valid(ent_valid), .ent_pres(ent_pres),
  .lk_vec(lk_vec)
);

// File: tb/tb_pvtlb_top.sv
`timescale 1ns/100ps
module tb_pvtlb_top;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_addr = '0;
  logic [21:0] cmd_ppn = '0;
  logic        cmd_preserve = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_hit;
  logic [21:0] lk_ppn;
  logic        fill_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pvtlb_top dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_ppn(cmd_ppn), .cmd_preserve(cmd_preserve),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_ppn(lk_ppn), .fill_err(fill_err)
  );

  // Behavioural reference model
  bit          m_v [N];
  bit          m_p [N];
  logic [21:0] m_t [N];
  logic [21:0] m_g [N];
  int          m_rr;
  bit          m_err;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin m_v[k] = 0; m_p[k] = 0; end
      m_rr = 0;
      m_err = 0;
    end else begin
      int idx;
      bit rot;
      logic [21:0] tg;
      m_err = 0;
      tg = cmd_addr[31:10];
      if (cmd_valid && cmd_op == 2'd1) begin
        idx = -1;
        rot = 0;
        for (int k = 0; k < N; k++) if (idx < 0 && m_v[k] && m_t[k] == tg) idx = k;
        for (int k = 0; k < N; k++) if (idx < 0 && !m_v[k]) idx = k;
        for (int k = 0; k < N; k++)
          if (idx < 0 && !m_p[(m_rr + k) % N]) begin idx = (m_rr + k) % N; rot = 1; end
        if (idx < 0) m_err = 1;
        else begin
          m_v[idx] = 1; m_p[idx] = cmd_preserve; m_t[idx] = tg; m_g[idx] = cmd_ppn;
          if (rot) m_rr = (idx + 1) % N;
        end
      end else if (cmd_valid && cmd_op == 2'd2) begin
        for (int k = 0; k < N; k++) if (!m_p[k]) m_v[k] = 0;
      end else if (cmd_valid && cmd_op == 2'd3) begin
        for (int k = 0; k < N; k++) if (m_v[k] && m_t[k] == tg) m_v[k] = 0;
      end
    end
  end

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Every-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      int cnt;
      logic [21:0] pg;
      cnt = 0;
      pg = '0;
      for (int k = 0; k < N; k++)
        if (m_v[k] && m_t[k] == lk_addr[31:10]) begin cnt++; pg = m_g[k]; end
      check(lk_hit == (cnt == 1), "R2", lk_hit, cnt == 1);
      check(lk_ppn == ((cnt == 1) ? pg : 22'd0), "R2", lk_ppn, (cnt == 1) ? pg : 22'd0);
      check(fill_err == m_err, "R9", fill_err, m_err);
    end
  end

  function automatic logic [31:0] va(logic [21:0] tg, logic [9:0] lo = 10'd0);
    return {tg, lo};
  endfunction

  // Called and returning at posedge + 1 ns
  task automatic cmd(logic [1:0] op, logic [31:0] a, logic [21:0] pg = '0, bit pin = 0);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_ppn = pg; cmd_preserve = pin;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_op = 2'd0;
  endtask

  task automatic fill(logic [21:0] tg, bit pin = 0);
    cmd(2'd1, va(tg), tg + 22'h100, pin);
  endtask

  task automatic look(logic [31:0] a, bit eh, logic [21:0] ep, string req);
    lk_addr = a;
    @(negedge clk); #0.5;
    check(lk_hit == eh, req, lk_hit, eh);
    if (eh) check(lk_ppn == ep, req, lk_ppn, ep);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    look(va(22'd5), 0, 0, "R1");
    for (int t = 1; t <= 8; t++) fill(22'(t), t <= 2);
    look(va(22'd8), 1, 22'h108, "R7");
    look(va(22'd1), 1, 22'h101, "R7");
    look(va(22'd3, 10'h3FF), 1, 22'h103, "R5");
    cmd(2'd1, va(22'd3), 22'h333, 0);
    look(va(22'd3), 1, 22'h333, "R6");
    look(va(22'd8), 1, 22'h108, "R6");
    fill(22'd9);
    look(va(22'd3), 0, 0, "R8");
    look(va(22'd9), 1, 22'h109, "R8");
    fill(22'd10);
    look(va(22'd4), 0, 0, "R8");
    look(va(22'd5), 1, 22'h105, "R8");
    cmd(2'd3, va(22'd5));
    look(va(22'd5), 0, 0, "R10");
    cmd(2'd2, 32'd0);
    look(va(22'd1), 1, 22'h101, "R3");
    look(va(22'd2), 1, 22'h102, "R3");
    look(va(22'd9), 0, 0, "R3");
    look(va(22'd8), 0, 0, "R3");
    cmd(2'd3, va(22'd1, 10'h2AB));
    look(va(22'd1), 0, 0, "R4");
    look(va(22'd2), 1, 22'h102, "R4");
    for (int t = 'h40; t <= 'h43; t++) fill(22'(t));
    cmd(2'd3, va(22'h41));
    look(va(22'h40), 1, 22'h140, "R11");
    look(va(22'h41), 0, 0, "R11");
    look(va(22'h42), 1, 22'h142, "R11");
    cmd(2'd2, 32'd0);
    for (int t = 'h50; t <= 'h56; t++) fill(22'(t), 1);
    fill(22'h60);
    check(fill_err == 1'b1, "R9", fill_err, 1);
    look(va(22'h60), 0, 0, "R9");
    check(fill_err == 1'b0, "R9", fill_err, 0);
    look(va(22'h50), 1, 22'h150, "R9");
    cmd(2'd3, va(22'h53));
    look(va(22'h53), 0, 0, "R4");
    fill(22'h60);
    check(fill_err == 1'b0, "R7", fill_err, 0);
    look(va(22'h60), 1, 22'h160, "R7");
    finish_run();
  end
endmodule